// File: doc/BRIEF.md
# Sharer-Tracking Directory Slice

This block is one slice of the shared last-level cache that records, for every block it holds, exactly which private caches keep a copy. Each entry has a valid flag, a tag, one presence bit per core, a dirty flag and the block data. A private cache sends three kinds of message on a single input port: a fetch request, a clean-eviction notice, and a dirty-eviction notice that carries the modified block. Each message is accepted with a valid/ready handshake, at a rate of one per cycle.

Every accepted message produces exactly one response on the next cycle. A fetch receives a data response. Every eviction, clean or dirty, receives a short acknowledgment. All responses go to the sender, in arrival order, on one output port that carries a destination core number. Because clean evictions are reported too, the presence bits stay exact. The traffic for each miss is one request plus one reply, whatever the core count.

The tag array is direct-mapped. When a fetch displaces a valid entry with a different tag, the block raises a one-cycle replacement event. The event shows the displaced address, its presence bits and its dirty flag, so that logic outside the slice can invalidate copies that inclusion no longer permits.

Top module: `dir_slice`

## Requirements
- R1: While reset is high and on the cycle after it, `in_ready`, `rsp_valid`, `proto_err` and `incl_victim` are low. After reset every entry is invalid, so the first fetch to any address is filled and raises no replacement event.
- R2: A fetch is `in_type`=0. It gives a data response (`rsp_kind`=0) on the cycle after acceptance, with `rsp_dest` equal to the sender and `rsp_addr` equal to the request address.
- R3: A fetch that misses fills the entry. The tag is taken from the address and only the sender's presence bit is set. The dirty flag is clear. The fill data is the block address zero-extended to the data width, and that value is returned.
- R4: A fetch that hits returns the stored data and adds the sender's presence bit, keeping any other bits.
- R5: Clean eviction is `in_type`=1 and dirty eviction is `in_type`=2. Every eviction, whatever the entry state, gives one acknowledgment (`rsp_kind`=1, `rsp_data`=0) to the sender on the next cycle. The total number of acknowledgments equals the total number of evictions.
- R6: A clean eviction from a cache whose presence bit is set clears only that bit and leaves `proto_err` low.
- R7: A dirty eviction from a cache whose presence bit is set stores `in_data`, sets the dirty flag and clears that bit. A later fetch returns the stored data.
- R8: An eviction for a block that is absent, or whose sender bit is clear, is still acknowledged. It pulses `proto_err` for one cycle, together with the acknowledgment, and changes no stored state.
- R9: A fetch that misses on a valid entry pulses `incl_victim` with its data response. `victim_addr`, `victim_sharers` and `victim_dirty` give the displaced address, presence bits and dirty flag.
- R10: Message type 3 is reserved. It is acknowledged with `proto_err` pulsed and leaves the stored state unchanged.
- R11: A response appears only on the cycle after an accepted message. With no message accepted, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Message present |
| in_ready | output | 1 | Slice can take a message |
| in_type | input | 2 | 0 fetch, 1 clean eviction, 2 dirty eviction, 3 reserved |
| in_src | input | CID_W | Sending core number |
| in_addr | input | ADDR_W | Block address; the low IDX_W bits select the set |
| in_data | input | BLOCK_W | Block data of a dirty eviction |
| rsp_valid | output | 1 | Response present |
| rsp_kind | output | 1 | 0 data response, 1 acknowledgment |
| rsp_dest | output | CID_W | Destination core |
| rsp_addr | output | ADDR_W | Block address of the response |
| rsp_data | output | BLOCK_W | Block data, zero for acknowledgments |
| proto_err | output | 1 | Eviction with no matching presence bit, or reserved type |
| incl_victim | output | 1 | A valid entry was displaced |
| victim_addr | output | ADDR_W | Displaced block address |
| victim_sharers | output | NCORES | Presence bits of the displaced block |
| victim_dirty | output | 1 | Dirty flag of the displaced block |

## Verification
A presence bit that is wrong inside the slice is not visible when it goes wrong. It shows later, on the first eviction from that core, as an unexpected or missing `proto_err`. It can also show when the set is displaced, as wrong `victim_sharers`. The bench therefore keeps its own model of every set and mixes evictions that match the model's holders with evictions that do not. Corrupted block data or a lost dirty flag shows on the next fetch or displacement of that set. Since each response is due exactly one cycle after acceptance, an ordering or dropped-reply fault appears at once.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    MSG_FETCH = 2'd0,
    MSG_EVC   = 2'd1,
    MSG_EVD   = 2'd2,
    MSG_RSV   = 2'd3
  } msg_e;

  typedef enum logic {
    RSP_DATA = 1'b0,
    RSP_ACK  = 1'b1
  } rsp_e;
endpackage

// File: rtl/dir_tag_store.sv
module dir_tag_store #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 9,
  parameter int NCORES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [NCORES-1:0] rd_shr,
  output logic              rd_dirty,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [NCORES-1:0] wr_shr,
  input  logic              wr_dirty
);
  localparam int SETS = 1 << IDX_W;

  logic [SETS-1:0]   vld;
  logic [TAG_W-1:0]  tag_mem [SETS];
  logic [NCORES-1:0] shr_mem [SETS];
  logic              drt_mem [SETS];

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (we) vld[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_mem[wr_idx] <= wr_tag;
      shr_mem[wr_idx] <= wr_shr;
      drt_mem[wr_idx] <= wr_dirty;
    end
  end

  assign rd_valid = vld[rd_idx];
  assign rd_tag   = tag_mem[rd_idx];
  assign rd_shr   = shr_mem[rd_idx];
  assign rd_dirty = drt_mem[rd_idx];
endmodule

// File: rtl/dir_data_store.sv
module dir_data_store #(
  parameter int IDX_W   = 3,
  parameter int BLOCK_W = 32
) (
  input  logic               clk,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [BLOCK_W-1:0] rd_data,
  input  logic               we,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [BLOCK_W-1:0] wr_data
);
  localparam int SETS = 1 << IDX_W;

  logic [BLOCK_W-1:0] mem [SETS];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
endmodule

// File: rtl/dir_decide.sv
module dir_decide
  import dir_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 3,
  parameter int BLOCK_W = 32,
  localparam int CID_W  = $clog2(NCORES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic [1:0]         mtype,
  input  logic [CID_W-1:0]   src,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [BLOCK_W-1:0] wdata_in,
  input  logic               e_valid,
  input  logic [TAG_W-1:0]   e_tag,
  input  logic [NCORES-1:0]  e_shr,
  input  logic               e_dirty,
  input  logic [BLOCK_W-1:0] e_data,
  output logic               tag_we,
  output logic [NCORES-1:0]  n_shr,
  output logic               n_dirty,
  output logic               data_we,
  output logic [BLOCK_W-1:0] n_data,
  output logic               r_kind,
  output logic [BLOCK_W-1:0] r_data,
  output logic               err,
  output logic               victim,
  output logic [ADDR_W-1:0]  v_addr
);
  logic [TAG_W-1:0]   tag;
  logic [IDX_W-1:0]   idx;
  logic [NCORES-1:0]  src_bit;
  logic [BLOCK_W-1:0] fill;
  logic               hit, holds;

  always_comb begin
    tag = addr[ADDR_W-1:IDX_W];
    idx = addr[IDX_W-1:0];
    src_bit = '0;
    src_bit[src] = 1'b1;
    fill = '0;
    fill[ADDR_W-1:0] = addr;
    hit   = e_valid && (e_tag == tag);
    holds = hit && ((e_shr & src_bit) != '0);
    v_addr = {e_tag, idx};

    tag_we  = 1'b0;
    n_shr   = e_shr;
    n_dirty = e_dirty;
    data_we = 1'b0;
    n_data  = wdata_in;
    r_kind  = RSP_ACK;
    r_data  = '0;
    err     = 1'b0;
    victim  = 1'b0;

    unique case (msg_e'(mtype))
      MSG_FETCH: begin
        r_kind = RSP_DATA;
        tag_we = 1'b1;
        if (hit) begin
          n_shr  = e_shr | src_bit;
          r_data = e_data;
        end else begin
          n_shr   = src_bit;
          n_dirty = 1'b0;
          data_we = 1'b1;
          n_data  = fill;
          r_data  = fill;
          victim  = e_valid;
        end
      end
      MSG_EVC: begin
        if (holds) begin
          tag_we = 1'b1;
          n_shr  = e_shr & ~src_bit;
        end else begin
          err = 1'b1;
        end
      end
      MSG_EVD: begin
        if (holds) begin
          tag_we  = 1'b1;
          n_shr   = e_shr & ~src_bit;
          n_dirty = 1'b1;
          data_we = 1'b1;
        end else begin
          err = 1'b1;
        end
      end
      default: err = 1'b1;
    endcase
  end
endmodule

// File: rtl/dir_slice.sv
module dir_slice
  import dir_pkg::*;
#(
  parameter int NCORES  = 4,
  parameter int ADDR_W  = 12,
  parameter int IDX_W   = 3,
  parameter int BLOCK_W = 32,
  localparam int CID_W  = $clog2(NCORES),
  localparam int TAG_W  = ADDR_W - IDX_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [1:0]         in_type,
  input  logic [CID_W-1:0]   in_src,
  input  logic [ADDR_W-1:0]  in_addr,
  input  logic [BLOCK_W-1:0] in_data,
  output logic               rsp_valid,
  output logic               rsp_kind,
  output logic [CID_W-1:0]   rsp_dest,
  output logic [ADDR_W-1:0]  rsp_addr,
  output logic [BLOCK_W-1:0] rsp_data,
  output logic               proto_err,
  output logic               incl_victim,
  output logic [ADDR_W-1:0]  victim_addr,
  output logic [NCORES-1:0]  victim_sharers,
  output logic               victim_dirty
);
  logic               rdy, acc;
  logic [IDX_W-1:0]   idx;
  logic               e_valid, e_dirty;
  logic [TAG_W-1:0]   e_tag;
  logic [NCORES-1:0]  e_shr;
  logic [BLOCK_W-1:0] e_data;
  logic               tag_we, data_we, n_dirty;
  logic [NCORES-1:0]  n_shr;
  logic [BLOCK_W-1:0] n_data, r_data;
  logic               r_kind, err, victim;
  logic [ADDR_W-1:0]  v_addr;

  assign acc      = in_valid && rdy;
  assign idx      = in_addr[IDX_W-1:0];
  assign in_ready = rdy;

  dir_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .NCORES(NCORES)) u_tags (
    .clk(clk), .rst(rst), .rd_idx(idx),
    .rd_valid(e_valid), .rd_tag(e_tag), .rd_shr(e_shr), .rd_dirty(e_dirty),
    .we(acc && tag_we), .wr_idx(idx), .wr_tag(in_addr[ADDR_W-1:IDX_W]),
    .wr_shr(n_shr), .wr_dirty(n_dirty)
  );

  dir_data_store #(.IDX_W(IDX_W), .BLOCK_W(BLOCK_W)) u_data (
    .clk(clk), .rd_idx(idx), .rd_data(e_data),
    .we(acc && data_we), .wr_idx(idx), .wr_data(n_data)
  );

  dir_decide #(.NCORES(NCORES), .ADDR_W(ADDR_W), .IDX_W(IDX_W), .BLOCK_W(BLOCK_W)) u_dec (
    .mtype(in_type), .src(in_src), .addr(in_addr), .wdata_in(in_data),
    .e_valid(e_valid), .e_tag(e_tag), .e_shr(e_shr), .e_dirty(e_dirty), .e_data(e_data),
    .tag_we(tag_we), .n_shr(n_shr), .n_dirty(n_dirty), .data_we(data_we), .n_data(n_data),
    .r_kind(r_kind), .r_data(r_data), .err(err), .victim(victim), .v_addr(v_addr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdy         <= 1'b0;
      rsp_valid   <= 1'b0;
      proto_err   <= 1'b0;
      incl_victim <= 1'b0;
    end else begin
      rdy         <= 1'b1;
      rsp_valid   <= acc;
      proto_err   <= acc && err;
      incl_victim <= acc && victim;
    end
  end

  always_ff @(posedge clk) begin
    if (acc) begin
      rsp_kind       <= r_kind;
      rsp_dest       <= in_src;
      rsp_addr       <= in_addr;
      rsp_data       <= r_data;
      victim_addr    <= v_addr;
      victim_sharers <= e_shr;
      victim_dirty   <= e_dirty;
    end
  end
endmodule

// File: rtl/dir_slice_chk.sv
module dir_slice_chk #(
  parameter int CID_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic             in_ready,
  input logic [1:0]       in_type,
  input logic [CID_W-1:0] in_src,
  input logic             rsp_valid,
  input logic             rsp_kind,
  input logic [CID_W-1:0] rsp_dest,
  input logic             proto_err,
  input logic             incl_victim
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!rsp_valid && !proto_err && !incl_victim && !in_ready));

  // R11
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(in_valid && in_ready));

  // R11
  accept_answered_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> rsp_valid);

  // R2
  fetch_gets_data_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_type == 2'd0) |=>
      (!rsp_kind && rsp_dest == $past(in_src)));

  // R5
  evict_gets_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_type != 2'd0) |=>
      (rsp_kind && rsp_dest == $past(in_src)));

  // R8
  err_with_ack_chk: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> (rsp_valid && rsp_kind));

  // R9
  victim_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    incl_victim |-> (rsp_valid && !rsp_kind));
endmodule

bind dir_slice dir_slice_chk #(.CID_W(CID_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_type(in_type), .in_src(in_src), .rsp_valid(rsp_valid),
  .rsp_kind(rsp_kind), .rsp_dest(rsp_dest), .proto_err(proto_err),
  .incl_victim(incl_victim)
);

// File: tb/dir_slice_test.sv
`timescale 1ns/1ps
module dir_slice_test;
  localparam int NC   = 4;
  localparam int AW   = 12;
  localparam int IW   = 3;
  localparam int BW   = 32;
  localparam int CW   = 2;
  localparam int SETS = 1 << IW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [1:0] in_type = '0;
  logic [CW-1:0] in_src = '0;
  logic [AW-1:0] in_addr = '0;
  logic [BW-1:0] in_data = '0;
  logic rsp_valid, rsp_kind, proto_err, incl_victim, victim_dirty;
  logic [CW-1:0] rsp_dest;
  logic [AW-1:0] rsp_addr, victim_addr;
  logic [BW-1:0] rsp_data;
  logic [NC-1:0] victim_sharers;

  always #10 clk = ~clk;

  dir_slice #(.NCORES(NC), .ADDR_W(AW), .IDX_W(IW), .BLOCK_W(BW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_type(in_type), .in_src(in_src), .in_addr(in_addr), .in_data(in_data),
    .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dest(rsp_dest),
    .rsp_addr(rsp_addr), .rsp_data(rsp_data), .proto_err(proto_err),
    .incl_victim(incl_victim), .victim_addr(victim_addr),
    .victim_sharers(victim_sharers), .victim_dirty(victim_dirty)
  );

  int checks = 0, errors = 0, evicts = 0, acks = 0;
  bit done = 1'b0;

  logic          m_valid [SETS];
  logic [AW-1:0] m_tag   [SETS];
  logic [NC-1:0] m_shr   [SETS];
  logic          m_dirty [SETS];
  logic [BW-1:0] m_data  [SETS];

  task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [BW-1:0] fill_of(logic [AW-1:0] a);
    return BW'(a);
  endfunction

  task automatic send(logic [1:0] t, logic [CW-1:0] s, logic [AW-1:0] a, logic [BW-1:0] d);
    int ix;
    logic [AW-1:0] tg;
    logic hit, holds, x_kind, x_err, x_vic, x_vd;
    logic [BW-1:0] x_data;
    logic [AW-1:0] x_va;
    logic [NC-1:0] x_vs, sb;
    string req;
    ix = int'(a[IW-1:0]);
    tg = a >> IW;
    sb = NC'(1) << s;
    hit = m_valid[ix] && m_tag[ix] == tg;
    holds = hit && ((m_shr[ix] & sb) != 0);
    x_err = 1'b0; x_vic = 1'b0; x_data = '0; x_kind = 1'b1;
    x_va = (m_tag[ix] << IW) | AW'(ix); x_vs = m_shr[ix]; x_vd = m_dirty[ix];
    if (t == 2'd0) begin
      x_kind = 1'b0;
      if (hit) begin
        req = "R4"; x_data = m_data[ix]; m_shr[ix] = m_shr[ix] | sb;
      end else begin
        req = m_valid[ix] ? "R9" : "R3";
        x_vic = m_valid[ix]; x_data = fill_of(a);
        m_valid[ix] = 1'b1; m_tag[ix] = tg; m_shr[ix] = sb;
        m_dirty[ix] = 1'b0; m_data[ix] = fill_of(a);
      end
    end else if (t == 2'd3) begin
      req = "R10"; x_err = 1'b1;
    end else begin
      evicts++;
      if (!holds) begin
        req = "R8"; x_err = 1'b1;
      end else if (t == 2'd1) begin
        req = "R6"; m_shr[ix] = m_shr[ix] & ~sb;
      end else begin
        req = "R7"; m_shr[ix] = m_shr[ix] & ~sb;
        m_dirty[ix] = 1'b1; m_data[ix] = d;
      end
    end
    in_valid = 1'b1; in_type = t; in_src = s; in_addr = a; in_data = d;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (t == 2'd1 || t == 2'd2) if (rsp_valid && rsp_kind) acks++;
    check("R11", "rsp_valid", 64'(rsp_valid), 64'd1);
    check(t == 2'd0 ? "R2" : "R5", "rsp_kind", 64'(rsp_kind), 64'(x_kind));
    check(t == 2'd0 ? "R2" : "R5", "rsp_dest", 64'(rsp_dest), 64'(s));
    check("R2", "rsp_addr", 64'(rsp_addr), 64'(a));
    check(req, "rsp_data", 64'(rsp_data), 64'(x_data));
    check(req, "proto_err", 64'(proto_err), 64'(x_err));
    check("R9", "incl_victim", 64'(incl_victim), 64'(x_vic));
    if (x_vic) begin
      check("R9", "victim_addr", 64'(victim_addr), 64'(x_va));
      check("R9", "victim_sharers", 64'(victim_sharers), 64'(x_vs));
      check("R9", "victim_dirty", 64'(victim_dirty), 64'(x_vd));
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < SETS; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_shr[i] = '0; m_dirty[i] = 1'b0; m_data[i] = '0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "in_ready in reset", 64'(in_ready), 64'd0);
    check("R1", "rsp_valid in reset", 64'(rsp_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "in_ready after reset", 64'(in_ready), 64'd1);
    check("R1", "proto_err after reset", 64'(proto_err), 64'd0);

    // R1 R3: first fetches fill without victim
    send(2'd0, 2'd1, 12'h015, '0);
    send(2'd0, 2'd2, 12'h015, '0);          // R4 hit adds sharer
    send(2'd1, 2'd1, 12'h015, '0);          // R6 clean eviction
    send(2'd1, 2'd1, 12'h015, '0);          // R8 bit already clear
    send(2'd2, 2'd2, 12'h015, 32'hCAFE0001); // R7 dirty write-back
    send(2'd0, 2'd3, 12'h015, '0);          // R7 data visible
    send(2'd3, 2'd0, 12'h015, 32'hFFFF);    // R10 reserved
    send(2'd1, 2'd0, 12'h0A6, '0);          // R8 absent block
    send(2'd0, 2'd0, 12'h02D, '0);          // R9 conflict on set 5
    in_valid = 1'b0;
    @(negedge clk);
    check("R11", "idle rsp_valid", 64'(rsp_valid), 64'd0);

    for (int n = 0; n < 600; n++) begin
      int r, ix;
      logic [1:0] t;
      logic [CW-1:0] s;
      logic [AW-1:0] tg;
      r = int'($urandom_range(99));
      t = (r < 45) ? 2'd0 : (r < 70) ? 2'd1 : (r < 95) ? 2'd2 : 2'd3;
      ix = int'($urandom_range(SETS - 1));
      tg = AW'($urandom_range(2));
      s = CW'($urandom_range(NC - 1));
      if (t != 2'd0 && m_valid[ix] && $urandom_range(3) != 0) begin
        tg = m_tag[ix];
        for (int k = 0; k < NC; k++) begin
          int c;
          c = (int'(s) + k) % NC;
          if (m_shr[ix][c]) begin s = CW'(c); break; end
        end
      end
      send(t, s, (tg << IW) | AW'(ix), $urandom);
      if ($urandom_range(7) == 0) begin
        @(negedge clk);
        check("R11", "gap rsp_valid", 64'(rsp_valid), 64'd0);
      end
    end

    check("R5", "ack count vs evictions", 64'(acks), 64'(evicts));
    done = 1'b1;
    summary();
    $finish;
  end
endmodule